// File: doc/BRIEF.md
# Serial-Bus Link Status and Control Registers

This block holds two 32-bit host-visible words for a serial-bus link layer. The status word sits at byte offset 04h and the control word at offset 08h. A simple synchronous host port reads and writes both words. Read data is registered and appears one cycle after the read strobe.

The status word collects events from the rest of the link:
- the most recent acknowledge code returned for a transmitted packet, with a valid flag that clears when the word is read and a sticky error flag;
- a link-on indication;
- the bus-manager-capable level;
- a round-trip ping measurement counted in 40 ns units;
- a host-writable link-power bit.

The control word drives the link's operating modes: receive and placement of self-identification packets, forced busy acknowledges, transaction enable, accelerated arbitration, and error-response mode. It also has a command bit that issues a one-cycle queue-reset pulse.

Bits follow big-endian numbering: bit n of a word is vector index 31-n. A bus-reset event clears only part of the status word and leaves the control word unchanged.

Top module: `lnk_regs`

## Requirements
- R1: After reset the status word at 04h reads 1400_0000h and the control word at 08h reads 4400_CA00h. The outputs txn_en_o, rx_selfid_o and lps_o are 1, and q_rst_o, send_busy_o and rdata_o are 0.
- R2: A bus_rst_i pulse clears status bits 7-15, 23, 24-27 and 31. It keeps bit 3 (bus-manager capable), bit 4 (link-on) and bit 5 (link-power). The control word is not changed.
- R3: linkon_det_i sets status bit 4 (mask 0800_0000h). A host write to 04h with that bit at 1 clears it. A detect in the same cycle as the clearing write wins.
- R4: An ack_vld_i pulse stores ack_code_i in status bits 24-27 (mask 0000_00F0h, bit 24 is the field MSB) and sets the valid flag in bit 31 (mask 0000_0001h). Every new acknowledge overwrites the code.
- R5: A read of 04h returns the valid flag and then clears it. If an acknowledge arrives in the same cycle as that read, the flag stays set.
- R6: An acknowledge received with ack_err_i at 1 sets status bit 23 (mask 0000_0100h). The bit stays set until a bus reset.
- R7: The ping count sits in status bits 7-15 (mask 01FF_0000h, bit 7 is the MSB). When ping_rx_i is sampled k cycles after ping_tx_i, the count is floor((k-1)/2), which is 40 ns units at a 20 ns clock. The count saturates at 511.
- R8: A write to 08h loads these control bits:
  - bit 1: rx_selfid_o
  - bit 2: selfid_sel_o
  - bit 4: forced busy
  - bit 5: txn_en_o
  - bit 7: accel_arb_o
  - bit 14: err_resp_o

  The loaded values read back. Bits 16-31 always read CA00h.
- R9: Writing 1 to control bit 10 (mask 0020_0000h) raises q_rst_o for exactly the one cycle after the write. The bit then reads 0.
- R10: send_busy_o is 1 while the forced-busy bit is 1. Otherwise it follows pkt_busy_i.
- R11: bus_rst_done_i sets control bit 0 (mask 8000_0000h). A host write does not clear it.
- R12: rdata_o presents a read one cycle after rd_en_i. Any address other than 04h and 08h reads 0. A write to 04h sets status bit 5 (lps_o) from the written data.
- R13: Status bit 3 (mask 1000_0000h) follows bm_capable_i with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr_i | input | 8 | Byte address of the host access |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Registered read data |
| bus_rst_i | input | 1 | Bus-reset event pulse |
| bus_rst_done_i | input | 1 | Bus-reset information valid pulse |
| bm_capable_i | input | 1 | Bus-manager-capable level |
| linkon_det_i | input | 1 | Link-on packet detected pulse |
| ack_vld_i | input | 1 | Acknowledge received pulse |
| ack_code_i | input | 4 | Received acknowledge code |
| ack_err_i | input | 1 | Parity or length error on the received acknowledge |
| ping_tx_i | input | 1 | Ping packet sent pulse |
| ping_rx_i | input | 1 | Ping response received pulse |
| pkt_busy_i | input | 1 | Normal busy request from the receive path |
| lps_o | output | 1 | Link power status |
| rx_selfid_o | output | 1 | Receive self-identification packets |
| selfid_sel_o | output | 1 | Self-identification packet placement select |
| txn_en_o | output | 1 | Transmitter and receiver enable |
| accel_arb_o | output | 1 | Accelerated arbitration enable |
| err_resp_o | output | 1 | Error-response mode |
| send_busy_o | output | 1 | Send a busy acknowledge |
| q_rst_o | output | 1 | One-cycle synchronous queue reset |

## Verification
A wrong valid flag or acknowledge field shows up on the next read of 04h. That read returns its value one cycle after the strobe, and the read after it exposes whether clear-on-read worked. Faults in bus-reset masking show as wrong preserved or cleared bits on the first read after the pulse. Control faults show on the mode outputs in the cycle after the write. A stuck or repeated queue reset shows on q_rst_o within two cycles. Ping miscounting shows as an off-by-one in bits 7-15 on the read that follows the response.

// File: rtl/lnk_regs_pkg.sv
package lnk_regs_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h08;

  // big-endian numbering: field bit n lives at vector index WORD_W-1-n
  localparam int S_BMC     = WORD_W - 1 - 3;
  localparam int S_LKON    = WORD_W - 1 - 4;
  localparam int S_LPS     = WORD_W - 1 - 5;
  localparam int S_PING_HI = WORD_W - 1 - 7;
  localparam int S_PING_LO = WORD_W - 1 - 15;
  localparam int S_ACKERR  = WORD_W - 1 - 23;
  localparam int S_ACK_HI  = WORD_W - 1 - 24;
  localparam int S_ACK_LO  = WORD_W - 1 - 27;
  localparam int S_ACKVLD  = WORD_W - 1 - 31;
  localparam int PING_W    = S_PING_HI - S_PING_LO + 1;
  localparam int ACK_W     = S_ACK_HI - S_ACK_LO + 1;

  localparam int C_IDVAL   = WORD_W - 1 - 0;
  localparam int C_RXSID   = WORD_W - 1 - 1;
  localparam int C_RSISEL  = WORD_W - 1 - 2;
  localparam int C_BSY     = WORD_W - 1 - 4;
  localparam int C_TREN    = WORD_W - 1 - 5;
  localparam int C_ACARB   = WORD_W - 1 - 7;
  localparam int C_RSTTR   = WORD_W - 1 - 10;
  localparam int C_ERRRESP = WORD_W - 1 - 14;
  localparam int C_FIX_W   = 16;
  localparam logic [C_FIX_W-1:0] C_FIX_VAL = 16'hCA00;

  localparam logic [WORD_W-1:0] STAT_RST = 32'h1400_0000;
  localparam logic [WORD_W-1:0] CTRL_RST = 32'h4400_CA00;

  typedef struct packed {
    logic rx_selfid;
    logic selfid_sel;
    logic force_busy;
    logic txn_en;
    logic accel_arb;
    logic err_resp;
  } ctrl_fields_t;
endpackage

// File: rtl/lnk_ping_timer.sv
module lnk_ping_timer #(
  parameter int CNT_W = 9,
  parameter int DIV   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tx_i,
  input  logic             rx_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int PS_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PS_W-1:0]  PS_LAST = PS_W'(DIV - 1);

  logic             run_q, run_d;
  logic [PS_W-1:0]  ps_q, ps_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    ps_d  = ps_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      run_d = 1'b0;
      ps_d  = '0;
      cnt_d = '0;
    end else if (tx_i) begin
      run_d = 1'b1;
      ps_d  = '0;
      cnt_d = '0;
    end else if (run_q) begin
      if (rx_i) begin
        run_d = 1'b0;
      end else if (ps_q == PS_LAST) begin
        ps_d = '0;
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end else begin
        ps_d = ps_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ps_q  <= '0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      ps_q  <= ps_d;
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

  // R7: while counting, the value never decreases (saturation, no wrap)
  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !clr_i && !tx_i |=> cnt_q >= $past(cnt_q));
  // R7: a response ends the measurement
  a_r7_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && rx_i && !clr_i && !tx_i |=> !run_q);
endmodule

// File: rtl/lnk_stat_reg.sv
module lnk_stat_reg
  import lnk_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              bmc_i,
  input  logic              linkon_det_i,
  input  logic              ack_vld_i,
  input  logic [ACK_W-1:0]  ack_code_i,
  input  logic              ack_err_i,
  input  logic [PING_W-1:0] ping_cnt_i,
  input  logic              wr_i,
  input  logic              wr_lkon_i,
  input  logic              wr_lps_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] word_o,
  output logic              lps_o
);
  logic             bmc_q, bmc_d;
  logic             lkon_q, lkon_d;
  logic             lps_q, lps_d;
  logic             err_q, err_d;
  logic             vld_q, vld_d;
  logic [ACK_W-1:0] code_q, code_d;

  always_comb begin
    bmc_d  = bmc_i;
    lkon_d = lkon_q;
    if (linkon_det_i)         lkon_d = 1'b1;
    else if (wr_i && wr_lkon_i) lkon_d = 1'b0;
    lps_d  = wr_i ? wr_lps_i : lps_q;
    code_d = code_q;
    vld_d  = vld_q;
    err_d  = err_q;
    if (bus_rst_i) begin
      code_d = '0;
      vld_d  = 1'b0;
      err_d  = 1'b0;
    end else if (ack_vld_i) begin
      code_d = ack_code_i;
      vld_d  = 1'b1;
      err_d  = err_q | ack_err_i;
    end else if (rd_i) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bmc_q  <= STAT_RST[S_BMC];
      lkon_q <= STAT_RST[S_LKON];
      lps_q  <= STAT_RST[S_LPS];
      err_q  <= STAT_RST[S_ACKERR];
      vld_q  <= STAT_RST[S_ACKVLD];
      code_q <= STAT_RST[S_ACK_HI:S_ACK_LO];
    end else begin
      bmc_q  <= bmc_d;
      lkon_q <= lkon_d;
      lps_q  <= lps_d;
      err_q  <= err_d;
      vld_q  <= vld_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    word_o                      = '0;
    word_o[S_BMC]               = bmc_q;
    word_o[S_LKON]              = lkon_q;
    word_o[S_LPS]               = lps_q;
    word_o[S_PING_HI:S_PING_LO] = ping_cnt_i;
    word_o[S_ACKERR]            = err_q;
    word_o[S_ACK_HI:S_ACK_LO]   = code_q;
    word_o[S_ACKVLD]            = vld_q;
  end

  assign lps_o = lps_q;

  // R4: a captured acknowledge is held with its valid flag
  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_i && !bus_rst_i |=> vld_q && (code_q == $past(ack_code_i)));
  // R5: a read with no new acknowledge drops the valid flag
  a_r5_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !ack_vld_i |=> !vld_q);
  // R2: bus reset clears the acknowledge state, keeps link power
  a_r2_bus_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i && !wr_i |=> !vld_q && !err_q && $stable(lps_q));
  // R3: detection always leaves link-on set
  a_r3_lkon_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    linkon_det_i |=> lkon_q);
  // R6: error flag is sticky outside bus reset
  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !bus_rst_i |=> err_q);
endmodule

// File: rtl/lnk_ctrl_reg.sv
module lnk_ctrl_reg
  import lnk_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              done_i,
  output logic [WORD_W-1:0] word_o,
  output ctrl_fields_t      fld_o,
  output logic              qrst_o
);
  localparam ctrl_fields_t FLD_RST = '{
    rx_selfid:  CTRL_RST[C_RXSID],
    selfid_sel: CTRL_RST[C_RSISEL],
    force_busy: CTRL_RST[C_BSY],
    txn_en:     CTRL_RST[C_TREN],
    accel_arb:  CTRL_RST[C_ACARB],
    err_resp:   CTRL_RST[C_ERRRESP]
  };

  ctrl_fields_t fld_q, fld_d;
  logic         idval_q, idval_d;
  logic         rsttr_q, rsttr_d;

  always_comb begin
    fld_d = fld_q;
    if (wr_i) begin
      fld_d.rx_selfid  = wdata_i[C_RXSID];
      fld_d.selfid_sel = wdata_i[C_RSISEL];
      fld_d.force_busy = wdata_i[C_BSY];
      fld_d.txn_en     = wdata_i[C_TREN];
      fld_d.accel_arb  = wdata_i[C_ACARB];
      fld_d.err_resp   = wdata_i[C_ERRRESP];
    end
    idval_d = idval_q | done_i;
    rsttr_d = wr_i & wdata_i[C_RSTTR];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q   <= FLD_RST;
      idval_q <= CTRL_RST[C_IDVAL];
      rsttr_q <= CTRL_RST[C_RSTTR];
    end else begin
      fld_q   <= fld_d;
      idval_q <= idval_d;
      rsttr_q <= rsttr_d;
    end
  end

  always_comb begin
    word_o               = '0;
    word_o[C_FIX_W-1:0]  = C_FIX_VAL;
    word_o[C_IDVAL]      = idval_q;
    word_o[C_RXSID]      = fld_q.rx_selfid;
    word_o[C_RSISEL]     = fld_q.selfid_sel;
    word_o[C_BSY]        = fld_q.force_busy;
    word_o[C_TREN]       = fld_q.txn_en;
    word_o[C_ACARB]      = fld_q.accel_arb;
    word_o[C_RSTTR]      = rsttr_q;
    word_o[C_ERRRESP]    = fld_q.err_resp;
  end

  assign fld_o  = fld_q;
  assign qrst_o = rsttr_q;

  // R9: the queue reset is a single-cycle pulse unless commanded again
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qrst_o && !(wr_i && wdata_i[C_RSTTR]) |=> !qrst_o);
  // R11: once valid, the ID flag stays set
  a_r11_idval_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_o[C_IDVAL] |=> word_o[C_IDVAL]);
  // R8: a control write reaches the enable output
  a_r8_tren_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> fld_o.txn_en == $past(wdata_i[C_TREN]));
endmodule

// File: rtl/lnk_regs.sv
module lnk_regs
  import lnk_regs_pkg::*;
#(
  parameter int UNIT_CYC = 2
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              bus_rst_i,
  input  logic              bus_rst_done_i,
  input  logic              bm_capable_i,
  input  logic              linkon_det_i,
  input  logic              ack_vld_i,
  input  logic [ACK_W-1:0]  ack_code_i,
  input  logic              ack_err_i,
  input  logic              ping_tx_i,
  input  logic              ping_rx_i,
  input  logic              pkt_busy_i,
  output logic              lps_o,
  output logic              rx_selfid_o,
  output logic              selfid_sel_o,
  output logic              txn_en_o,
  output logic              accel_arb_o,
  output logic              err_resp_o,
  output logic              send_busy_o,
  output logic              q_rst_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic sel_stat, sel_ctrl;
  assign sel_stat = (addr_i == OFS_STAT);
  assign sel_ctrl = (addr_i == OFS_CTRL);

  logic [PING_W-1:0] ping_cnt;
  logic [WORD_W-1:0] stat_word, ctrl_word;
  ctrl_fields_t      fld;

  lnk_ping_timer #(.CNT_W(PING_W), .DIV(UNIT_CYC)) u_ping (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .clr_i   (bus_rst_i),
    .tx_i    (ping_tx_i),
    .rx_i    (ping_rx_i),
    .count_o (ping_cnt)
  );

  lnk_stat_reg u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .bus_rst_i    (bus_rst_i),
    .bmc_i        (bm_capable_i),
    .linkon_det_i (linkon_det_i),
    .ack_vld_i    (ack_vld_i),
    .ack_code_i   (ack_code_i),
    .ack_err_i    (ack_err_i),
    .ping_cnt_i   (ping_cnt),
    .wr_i         (wr_en_i && sel_stat),
    .wr_lkon_i    (wdata_i[S_LKON]),
    .wr_lps_i     (wdata_i[S_LPS]),
    .rd_i         (rd_en_i && sel_stat),
    .word_o       (stat_word),
    .lps_o        (lps_o)
  );

  lnk_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .wr_i    (wr_en_i && sel_ctrl),
    .wdata_i (wdata_i),
    .done_i  (bus_rst_done_i),
    .word_o  (ctrl_word),
    .fld_o   (fld),
    .qrst_o  (q_rst_o)
  );

  logic [WORD_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en_i) begin
      if (sel_stat)      rdata_d = stat_word;
      else if (sel_ctrl) rdata_d = ctrl_word;
      else               rdata_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o      = rdata_q;
  assign rx_selfid_o  = fld.rx_selfid;
  assign selfid_sel_o = fld.selfid_sel;
  assign txn_en_o     = fld.txn_en;
  assign accel_arb_o  = fld.accel_arb;
  assign err_resp_o   = fld.err_resp;
  assign send_busy_o  = fld.force_busy | pkt_busy_i;

  // R12: unmapped addresses read as zero on the next cycle
  a_r12_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_en_i && !sel_stat && !sel_ctrl |=> rdata_o == '0);
  // R5: a read racing a new acknowledge still reports valid afterwards
  a_r5_race_keeps: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_en_i && sel_stat && ack_vld_i && !bus_rst_i |=> stat_word[S_ACKVLD]);
endmodule

// File: tb/lnk_regs_tb_top.sv
module lnk_regs_tb_top;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bus_rst = 1'b0, bus_done = 1'b0, bm_cap = 1'b1, lk_det = 1'b0;
  logic        ack_vld = 1'b0, ack_err = 1'b0;
  logic [3:0]  ack_code = '0;
  logic        ping_tx = 1'b0, ping_rx = 1'b0, pkt_busy = 1'b0;
  logic        lps, rx_sid, sid_sel, tren, acarb, errresp, sbusy, qrst;

  always #10 clk = ~clk;  // 50 MHz

  lnk_regs dut_i (
    .clk_i(clk), .arst_ni(arst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .bus_rst_i(bus_rst), .bus_rst_done_i(bus_done),
    .bm_capable_i(bm_cap), .linkon_det_i(lk_det), .ack_vld_i(ack_vld),
    .ack_code_i(ack_code), .ack_err_i(ack_err), .ping_tx_i(ping_tx), .ping_rx_i(ping_rx),
    .pkt_busy_i(pkt_busy), .lps_o(lps), .rx_selfid_o(rx_sid), .selfid_sel_o(sid_sel),
    .txn_en_o(tren), .accel_arb_o(acarb), .err_resp_o(errresp), .send_busy_o(sbusy),
    .q_rst_o(qrst)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare read data one cycle after each strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12 unexpected read data actual=%08h expected=none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_ack(input logic [31:0] exp, input logic [3:0] code, input string tag);
    @(negedge clk);
    addr = 8'h04; rd_en = 1'b1; ack_vld = 1'b1; ack_code = code; ack_err = 1'b0;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; ack_vld = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack(input logic [3:0] code, input logic err);
    @(negedge clk);
    ack_vld = 1'b1; ack_code = code; ack_err = err;
    @(negedge clk);
    ack_vld = 1'b0; ack_err = 1'b0;
  endtask

  task automatic ping(input int k);
    @(negedge clk); ping_tx = 1'b1;
    @(negedge clk); ping_tx = 1'b0;
    repeat (k - 1) @(negedge clk);
    ping_rx = 1'b1;
    @(negedge clk); ping_rx = 1'b0;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 txn_en", {31'd0, tren}, 32'd1);
    chk("R1 rx_selfid", {31'd0, rx_sid}, 32'd1);
    chk("R1 lps", {31'd0, lps}, 32'd1);
    chk("R1 q_rst", {31'd0, qrst}, 32'd0);
    chk("R1 send_busy", {31'd0, sbusy}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rd(8'h04, 32'h1400_0000, "R1 status reset");
    rd(8'h08, 32'h4400_CA00, "R1 control reset");
    rd(8'h0C, 32'h0000_0000, "R12 unmapped");
    // R4 / R5 acknowledge capture and clear-on-read
    ack(4'hA, 1'b0);
    rd(8'h04, 32'h1400_00A1, "R4 capture A");
    rd(8'h04, 32'h1400_00A0, "R5 cleared by read");
    ack(4'h3, 1'b1);
    rd(8'h04, 32'h1400_0131, "R6 error flagged R4 overwrite");
    rd(8'h04, 32'h1400_0130, "R5 cleared again");
    rd_ack(32'h1400_0130, 4'h5, "R5 race read");
    rd(8'h04, 32'h1400_0151, "R5 race keeps valid R6 sticky");
    rd(8'h04, 32'h1400_0150, "R5 clear after race");
    // R3 link-on
    @(negedge clk); lk_det = 1'b1;
    @(negedge clk); lk_det = 1'b0;
    rd(8'h04, 32'h1C00_0150, "R3 link-on set");
    wr(8'h04, 32'h0C00_0000);
    rd(8'h04, 32'h1400_0150, "R3 link-on cleared");
    wr(8'h04, 32'h0000_0000);
    chk("R12 lps write", {31'd0, lps}, 32'd0);
    rd(8'h04, 32'h1000_0150, "R12 lps bit");
    wr(8'h04, 32'h0400_0000);
    @(negedge clk);
    addr = 8'h04; wdata = 32'h0C00_0000; wr_en = 1'b1; lk_det = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; lk_det = 1'b0;
    rd(8'h04, 32'h1C00_0150, "R3 detect wins");
    // R7 ping
    ping(21);
    rd(8'h04, 32'h1C0A_0150, "R7 ping count");
    // R2 bus reset
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    rd(8'h04, 32'h1C00_0000, "R2 status partial clear");
    rd(8'h08, 32'h4400_CA00, "R2 control untouched");
    // R11 id valid
    @(negedge clk); bus_done = 1'b1;
    @(negedge clk); bus_done = 1'b0;
    rd(8'h08, 32'hC400_CA00, "R11 idval set");
    // R8 / R10 control fields
    wr(8'h08, 32'hA902_0000);
    chk("R8 selfid_sel", {31'd0, sid_sel}, 32'd1);
    chk("R8 rx_selfid", {31'd0, rx_sid}, 32'd0);
    chk("R8 txn_en", {31'd0, tren}, 32'd0);
    chk("R8 accel_arb", {31'd0, acarb}, 32'd1);
    chk("R8 err_resp", {31'd0, errresp}, 32'd1);
    chk("R10 forced busy", {31'd0, sbusy}, 32'd1);
    rd(8'h08, 32'hA902_CA00, "R8 readback R11 kept");
    wr(8'h08, 32'h0400_0000);
    chk("R10 busy released", {31'd0, sbusy}, 32'd0);
    pkt_busy = 1'b1; #1;
    chk("R10 normal busy", {31'd0, sbusy}, 32'd1);
    pkt_busy = 1'b0; #1;
    chk("R10 normal idle", {31'd0, sbusy}, 32'd0);
    // R9 queue reset pulse
    wr(8'h08, 32'h0420_0000);
    chk("R9 pulse high", {31'd0, qrst}, 32'd1);
    @(negedge clk);
    chk("R9 pulse low", {31'd0, qrst}, 32'd0);
    rd(8'h08, 32'h8400_CA00, "R9 self-cleared");
    // R7 saturation
    ping(1100);
    rd(8'h04, 32'h1DFF_0000, "R7 saturate");
    // R13 bus-manager-capable follows input
    @(negedge clk); bm_cap = 1'b0;
    @(negedge clk);
    rd(8'h04, 32'h0DFF_0000, "R13 bmc low");
    bm_cap = 1'b1;
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R12 missing read data actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule